// File: doc/BRIEF.md
# High-speed burst sequencer for one serial data lane

This block runs one data lane of a low-power/high-speed differential link through a full high-speed burst. While idle it holds the stop state (both single-ended lines high). It begins a burst only when the payload stream has a byte waiting and the clock lane reports that its lead time is satisfied. It then walks down through a request step (P low, N high) and a bridge step (both lines low). Next it drives differential zero, sends a fixed synchronisation word and streams the payload one bit per clock.

Payload arrives as bytes on a valid/ready stream. A burst closes after the byte flagged as final, or early if the stream runs dry while a byte is due. The closing is a tail interval in which the lane holds the complement of the last bit it sent. The lane then returns straight to the stop state and rests there for a programmable time before another burst may begin.

Every interval is a cycle count taken from an input, so one netlist serves any line rate. Serialisation to line rate and the analog drivers sit outside this block.

Top module: `hs_lane_seq`

## Requirements
- R1: While reset is asserted and after it is released, the lane shows stop state (`lp_p`=1, `lp_n`=1), `hs_en`=0, `hs_bit`=0, `s_ready`=0 and `err_underflow`=0.
- R2: From stop state the lane leaves only in the cycle after a clock edge that samples both `s_valid`=1 and `clk_lane_ready`=1. Until then it stays in stop state, and the first state after it is the request step (`lp_p`=0, `lp_n`=1).
- R3: The request step lasts `cnt_lp01` cycles. It is followed by the bridge step (`lp_p`=0, `lp_n`=0, `hs_en`=0) for `cnt_bridge` cycles.
- R4: After the bridge step, `hs_en`=1 with `hs_bit`=0 and both LP lines low for `cnt_hs0` cycles. High-speed drive is only ever entered from the bridge step.
- R5: The synchronisation word 8'hB8 follows, least significant bit first, one bit per cycle: 0,0,0,1,1,1,0,1.
- R6: Payload bytes follow with no gap, least significant bit first. `s_ready` is 1 exactly in the cycle carrying the final bit of the sync word and the final bit of each payload byte that was not flagged by `s_last`. A byte is taken at a clock edge where `s_valid` and `s_ready` are both 1.
- R7: After the final bit of a byte taken with `s_last`=1, no further byte is taken. For `cnt_tail` cycles the lane drives `hs_en`=1 with `hs_bit` equal to the complement of the last bit sent.
- R8: The tail goes directly to stop state with `hs_en`=0. Stop state is held for `cnt_rest` cycles, during which `s_valid` and `clk_lane_ready` are ignored.
- R9: If `s_ready`=1 while `s_valid`=0, `err_underflow` becomes 1 from the next cycle and the burst ends with the tail of R7 (complement of the last bit sent). The flag holds until the next burst leaves stop state.
- R10: An interval count of 0 is treated as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte/bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clk_lane_ready | input | 1 | Clock lane reports its lead time is met |
| cnt_lp01 | input | CNT_W | Request step length in cycles |
| cnt_bridge | input | CNT_W | Bridge step length in cycles |
| cnt_hs0 | input | CNT_W | Differential zero length before sync |
| cnt_tail | input | CNT_W | Tail length in cycles |
| cnt_rest | input | CNT_W | Stop state hold after a burst |
| s_valid | input | 1 | Payload byte available |
| s_data | input | BYTE_W | Payload byte |
| s_last | input | 1 | Byte is the final one of the burst |
| s_ready | output | 1 | Byte accepted at this edge if valid |
| lp_p | output | 1 | Low-power level of the P line |
| lp_n | output | 1 | Low-power level of the N line |
| hs_en | output | 1 | High-speed driver enabled |
| hs_bit | output | 1 | High-speed bit for this cycle |
| err_underflow | output | 1 | Stream ran dry inside a burst |

## Verification
Several properties are checked on every cycle. High-speed drive starts only from the bridge step, and it ends straight into stop state. Stop state is left only through the request step and only after the clock lane was ready. `s_ready` is raised only during high-speed drive. An accepted byte's low bit is the next bit on the lane. A burst's close flips the line bit. The error flag rises only after an unmet ready.

The exact length of every interval, the sync bit pattern, the order of payload bits, the absence of a ready after a final byte, and the persistence and clearing of the error flag can only be shown by the bench. Its per-cycle reference stream covers these under several count settings, including zero counts and underflows both right after the sync word and inside the payload.

// File: rtl/hsl_pkg.sv
package hsl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_PREP,
      ST_ZERO,
      ST_SYNC,
      ST_DATA,
      ST_TRAIL,
      ST_EXIT
   } hsl_state_e;

   localparam logic [7:0] HSL_SYNC_DEF = 8'hB8;

endpackage

// File: rtl/hsl_interval.sv
module hsl_interval #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] len,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= (len == '0) ? '0 : len - ONE;
      else if (cnt != '0)
         cnt <= cnt - ONE;
   end

   assign done = (cnt == '0);

endmodule

// File: rtl/hsl_bitser.sv
module hsl_bitser #(
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_val,
   input  logic              advance,
   output logic              bit_o,
   output logic              eob
);
   localparam int IDX_W = $clog2(BYTE_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

   logic [BYTE_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_q <= '0;
         idx_q  <= '0;
      end else if (load) begin
         word_q <= load_val;
         idx_q  <= '0;
      end else if (advance) begin
         idx_q  <= eob ? '0 : idx_q + IDX_ONE;
      end
   end

   assign eob = (idx_q == LAST_IDX);

   generate
      if (MSB_FIRST) begin : g_msb
         assign bit_o = word_q[LAST_IDX - idx_q];
      end else begin : g_lsb
         assign bit_o = word_q[idx_q];
      end
   endgenerate

endmodule

// File: rtl/hs_lane_seq.sv
module hs_lane_seq
   import hsl_pkg::*;
#(
   parameter int                BYTE_W    = 8,
   parameter int                CNT_W     = 8,
   parameter bit                MSB_FIRST = 1'b0,
   parameter logic [BYTE_W-1:0] SYNC_WORD = BYTE_W'(HSL_SYNC_DEF)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clk_lane_ready,
   input  logic [CNT_W-1:0]  cnt_lp01,
   input  logic [CNT_W-1:0]  cnt_bridge,
   input  logic [CNT_W-1:0]  cnt_hs0,
   input  logic [CNT_W-1:0]  cnt_tail,
   input  logic [CNT_W-1:0]  cnt_rest,
   input  logic              s_valid,
   input  logic [BYTE_W-1:0] s_data,
   input  logic              s_last,
   output logic              s_ready,
   output logic              lp_p,
   output logic              lp_n,
   output logic              hs_en,
   output logic              hs_bit,
   output logic              err_underflow
);

   generate
      if (BYTE_W < 2 || (BYTE_W & (BYTE_W - 1)) != 0) begin : g_bad_byte
         $error("hs_lane_seq: BYTE_W must be a power of two >= 2");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("hs_lane_seq: CNT_W must be at least 2");
      end
   endgenerate

   hsl_state_e        st, st_nx;
   logic              last_q, tail_q, err_q;
   logic              tmr_load, tmr_done;
   logic [CNT_W-1:0]  tmr_len;
   logic              ser_load, ser_adv, ser_bit, ser_eob;
   logic [BYTE_W-1:0] ser_val;
   logic              rdy, xfer, in_ser, ends_burst;

   assign in_ser     = (st == ST_SYNC) || (st == ST_DATA);
   assign rdy        = ((st == ST_SYNC) || ((st == ST_DATA) && !last_q)) && ser_eob;
   assign xfer       = rdy && s_valid;
   assign ends_burst = in_ser && ser_eob && !xfer;

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (s_valid && clk_lane_ready) st_nx = ST_REQ;
         ST_REQ:   if (tmr_done) st_nx = ST_PREP;
         ST_PREP:  if (tmr_done) st_nx = ST_ZERO;
         ST_ZERO:  if (tmr_done) st_nx = ST_SYNC;
         ST_SYNC,
         ST_DATA:  if (ser_eob)  st_nx = xfer ? ST_DATA : ST_TRAIL;
         ST_TRAIL: if (tmr_done) st_nx = ST_EXIT;
         ST_EXIT:  if (tmr_done) st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_comb begin
      unique case (st_nx)
         ST_REQ:   tmr_len = cnt_lp01;
         ST_PREP:  tmr_len = cnt_bridge;
         ST_ZERO:  tmr_len = cnt_hs0;
         ST_TRAIL: tmr_len = cnt_tail;
         ST_EXIT:  tmr_len = cnt_rest;
         default:  tmr_len = '0;
      endcase
   end

   assign tmr_load = (st_nx != st);

   hsl_interval #(.CNT_W(CNT_W)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .load (tmr_load),
      .len  (tmr_len),
      .done (tmr_done)
   );

   assign ser_load = xfer || ((st == ST_ZERO) && tmr_done);
   assign ser_val  = xfer ? s_data : SYNC_WORD;
   assign ser_adv  = in_ser;

   hsl_bitser #(.BYTE_W(BYTE_W), .MSB_FIRST(MSB_FIRST)) u_ser (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ser_load),
      .load_val(ser_val),
      .advance (ser_adv),
      .bit_o   (ser_bit),
      .eob     (ser_eob)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         last_q <= 1'b0;
         tail_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st <= st_nx;
         if ((st == ST_ZERO) && tmr_done) last_q <= 1'b0;
         else if (xfer)                   last_q <= s_last;
         if (in_ser && ser_eob) tail_q <= ser_bit;
         if ((st == ST_IDLE) && (st_nx == ST_REQ)) err_q <= 1'b0;
         else if (rdy && !s_valid)                 err_q <= 1'b1;
      end
   end

   assign s_ready       = rdy;
   assign lp_p          = (st == ST_IDLE) || (st == ST_EXIT);
   assign lp_n          = (st == ST_IDLE) || (st == ST_EXIT) || (st == ST_REQ);
   assign hs_en         = (st == ST_ZERO) || in_ser || (st == ST_TRAIL);
   assign hs_bit        = in_ser ? ser_bit : ((st == ST_TRAIL) ? ~tail_q : 1'b0);
   assign err_underflow = err_q;

   // R2: stop state is left only through the request step, after the clock lane was ready
   assert_leave_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(lp_p && lp_n) && !(lp_p && lp_n)) |-> ($past(clk_lane_ready) && !lp_p && lp_n));

   // R4: high-speed drive begins only out of the bridge step
   assert_hs_from_bridge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(!lp_p && !lp_n));

   // R5, R6: an accepted byte's first bit is on the lane in the next cycle
   assert_bit_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && s_valid) |=> (hs_bit == $past(MSB_FIRST ? s_data[BYTE_W-1] : s_data[0])));

   // R6: readiness only while the high-speed driver is on
   assert_ready_in_hs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> hs_en);

   // R7: the tail holds the complement of the last bit sent
   assert_tail_flips_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ends_burst |=> (hs_bit == !$past(hs_bit)));

   // R8: the driver turns off straight into stop state
   assert_tail_to_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_en) |-> (lp_p && lp_n));

   // R9: the error flag rises only after a ready that found no byte
   assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_underflow) |-> $past(s_ready && !s_valid));

endmodule

// File: tb/sim_hs_lane_seq.sv
`timescale 1ns/1ps
module sim_hs_lane_seq;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       clk_lane_ready;
   logic [7:0] cnt_lp01, cnt_bridge, cnt_hs0, cnt_tail, cnt_rest;
   logic       s_valid;
   logic [7:0] s_data;
   logic       s_last;
   logic       s_ready, lp_p, lp_n, hs_en, hs_bit, err_underflow;

   int checks = 0;
   int fails  = 0;

   logic [5:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] pay_q[$];

   always #2.5 clk = ~clk;

   hs_lane_seq u0 (
      .clk(clk), .rst_n(rst_n), .clk_lane_ready(clk_lane_ready),
      .cnt_lp01(cnt_lp01), .cnt_bridge(cnt_bridge), .cnt_hs0(cnt_hs0),
      .cnt_tail(cnt_tail), .cnt_rest(cnt_rest),
      .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
      .lp_p(lp_p), .lp_n(lp_n), .hs_en(hs_en), .hs_bit(hs_bit),
      .err_underflow(err_underflow)
   );

   function automatic int eff(input logic [7:0] c);
      return (c == 8'd0) ? 1 : int'(c);
   endfunction

   // expected vector: {err, lp_p, lp_n, hs_en, hs_bit, s_ready}
   task automatic push(input int n, input logic [5:0] v, input string t);
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(v);
         tag_q.push_back(t);
      end
   endtask

   task automatic cmp(input logic [5:0] e, input string t);
      logic [5:0] act;
      act = {err_underflow, lp_p, lp_n, hs_en, hs_bit, s_ready};
      checks++;
      if (act !== e) begin
         fails++;
         $display("FAIL %s at %0t: actual=%b expected=%b (err,lp_p,lp_n,hs_en,hs_bit,ready)",
                  t, $time, act, e);
      end
   endtask

   task automatic idle_cycles(input int n, input logic e, input logic v,
                              input logic cr, input string t);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cmp({e, 5'b11000}, t);
         s_valid        = v;
         clk_lane_ready = cr;
      end
   endtask

   // stall < 0: no underflow; otherwise the byte index that is withheld
   task automatic run_burst(input int stall, input logic poke_rest);
      logic [7:0] sync;
      logic       last_bit, e;
      int         n, nsent, idx;
      logic       px;
      logic [5:0] ev;
      string      tg;
      sync  = 8'hB8;
      n     = pay_q.size();
      e     = (stall >= 0);
      nsent = e ? stall : n;
      push(eff(cnt_lp01),   6'b001000, "R3");
      push(eff(cnt_bridge), 6'b000000, "R3");
      push(eff(cnt_hs0),    6'b000100, "R4");
      for (int i = 0; i < 8; i++)
         push(1, {4'b0001, sync[i], (i == 7)}, "R5");
      last_bit = sync[7];
      for (int j = 0; j < nsent; j++) begin
         for (int i = 0; i < 8; i++)
            push(1, {4'b0001, pay_q[j][i], ((i == 7) && (j != n - 1))}, "R6");
         last_bit = pay_q[j][7];
      end
      push(eff(cnt_tail), {e, 3'b001, ~last_bit, 1'b0}, e ? "R9" : "R7");
      push(eff(cnt_rest), {e, 5'b11000}, "R8");

      idx            = 0;
      px             = 1'b0;
      s_valid        = 1'b1;
      s_data         = pay_q[0];
      s_last         = (n == 1);
      clk_lane_ready = 1'b1;
      while (exp_q.size() > 0) begin
         @(negedge clk);
         if (px) idx++;
         ev = exp_q.pop_front();
         tg = tag_q.pop_front();
         cmp(ev, tg);
         if (poke_rest && exp_q.size() > 0 && exp_q.size() <= eff(cnt_rest)) begin
            s_valid = 1'b1;   // R8: must be ignored during the rest hold
            s_data  = 8'h00;
            s_last  = 1'b0;
         end else begin
            s_valid = (idx < n) && (idx != stall);
            s_data  = (idx < n) ? pay_q[idx] : 8'h00;
            s_last  = (idx == n - 1);
         end
         px = s_ready && s_valid;
      end
      s_valid        = 1'b0;
      clk_lane_ready = 1'b0;
      idle_cycles(3, e, 1'b0, 1'b0, e ? "R9" : "R8");
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n          = 1'b0;
      clk_lane_ready = 1'b0;
      s_valid        = 1'b0;
      s_data         = 8'h00;
      s_last         = 1'b0;
      cnt_lp01 = 8'd3; cnt_bridge = 8'd4; cnt_hs0 = 8'd5; cnt_tail = 8'd6; cnt_rest = 8'd4;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         cmp(6'b011000, "R1");
      end
      rst_n = 1'b1;
      idle_cycles(2, 1'b0, 1'b0, 1'b0, "R1");
      // R2: data waiting but clock lane not ready
      idle_cycles(5, 1'b0, 1'b1, 1'b0, "R2");
      // R2: clock lane ready, nothing to send
      idle_cycles(3, 1'b0, 1'b0, 1'b1, "R2");

      pay_q = {8'hA5, 8'h3C, 8'hF0};
      run_burst(-1, 1'b0);

      // R10: all counts zero act as one cycle; R8 rest hold ignores valid
      cnt_lp01 = 8'd0; cnt_bridge = 8'd0; cnt_hs0 = 8'd0; cnt_tail = 8'd0; cnt_rest = 8'd0;
      pay_q = {8'h01};
      run_burst(-1, 1'b1);

      // R9: underflow inside the payload
      cnt_lp01 = 8'd2; cnt_bridge = 8'd2; cnt_hs0 = 8'd3; cnt_tail = 8'd2; cnt_rest = 8'd3;
      pay_q = {8'h7E, 8'h81, 8'h55};
      run_burst(1, 1'b0);

      // R9: underflow right after sync; flag cleared by the new burst
      pay_q = {8'h00, 8'hFF};
      run_burst(0, 1'b0);

      cnt_lp01 = 8'd1; cnt_bridge = 8'd5; cnt_hs0 = 8'd1; cnt_tail = 8'd9; cnt_rest = 8'd6;
      pay_q = {8'h80, 8'h6B, 8'hC4, 8'h12};
      run_burst(-1, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule